// File: doc/BRIEF.md
# External Memory Access Controller

This block sits between a CPU's data-memory port and two places a byte can live: a 4 KB internal scratch RAM and an external parallel bus. For every single-byte request it decides where the byte lives. For the external bus it then runs a complete bus cycle: it drives the address, produces an address-latch strobe when the pins are shared, and pulses a read or write strobe. Each request is either a full 16-bit address or a short request. A short request carries only a low byte, and its upper byte comes from the address-high port latch value or from a page register.

An 8-bit configuration register sets four things. Its routing field picks one of four routes, three of which decide by a boundary at 0x1000. The other fields pick the pin style (shared address/data or separate pins), which of two pin groups carries the bus, and the width of the address-latch pulse. Everything the routing decision needs is captured when a request is accepted. Software can therefore rewrite either register at any time without corrupting an access that is already in flight.

Top module: `emc_ctrl`

## Requirements
- R1: After reset the configuration register reads 0x03 and the page register reads 0x00. `busy` and `done` are low. Every pin group is idle: address-latch strobe 0, `rd_n`/`wr_n` 1, all address and data outputs 0 and output enables 0.
- R2: Configuration bits 7:6 always read 0 and writes to them are ignored. Bits 5:0 read back exactly as written.
- R3: With routing field cfg[3:2]=00, every access uses the internal RAM at address bits 11:0, and higher address bits are ignored. A short access takes its upper byte from the page register. `done` rises in the cycle after acceptance, with read data on `rdata`, and no pin group leaves idle.
- R4: With cfg[3:2]=01, an effective address below 0x1000 goes to internal RAM and one at or above 0x1000 goes external. A short access (`req_short`=1, only `req_addr[7:0]` used) takes its upper byte from `hi_latch`.
- R5: With cfg[3:2]=10, the same 0x1000 split applies, but a short access takes its upper byte from the page register.
- R6: With cfg[3:2]=11, every access goes external. A short access takes its upper byte from the page register.
- R7: cfg[5]=0 places the bus on pin group 0 (bits [7:0] of each packed pin bus, index 0). cfg[5]=1 places it on group 1 (bits [15:8], index 1). The other group stays idle.
- R8: With cfg[4]=0 (shared pins), the address-latch strobe is high for W=cfg[1:0]+1 cycles, starting the cycle after acceptance. During that time the address low byte is driven on the data pins with the output enable set. The strobe is then low for W cycles, followed by one strobe cycle. The upper address byte sits on `ext_ahi` throughout, and `ext_alo` stays 0.
- R9: With cfg[4]=1 (separate pins), no address-latch strobe occurs. One setup cycle presents the upper and low address bytes on `ext_ahi`/`ext_alo`, followed by one strobe cycle, and both address bytes are held until the end.
- R10: In the strobe cycle a read drives `rd_n` low, while a write drives `wr_n` low and puts the write byte on the data pins with the output enable set. `done` is high in the following cycle and `busy` falls in that same cycle. Read data is the `ext_dq_i` byte of the active group as sampled at the end of the strobe cycle.
- R11: Routing, pin style, pin group and pulse width come from the configuration in effect when a request is accepted. A configuration write in the same cycle or during the access takes effect only for later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration register write enable |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Configuration register value |
| page_wr | input | 1 | Page register write enable |
| page_wdata | input | 8 | Page write value |
| page_rdata | output | 8 | Page register value |
| hi_latch | input | 8 | Current address-high port latch value |
| req | input | 1 | Access request; accepted when `busy` is low |
| req_we | input | 1 | 1 = write, 0 = read |
| req_short | input | 1 | 1 = 8-bit-addressed access |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | External access in progress |
| done | output | 1 | Access complete, one-cycle pulse |
| rdata | output | 8 | Read byte, valid while `done` is high |
| ext_ale | output | 2 | Address-latch strobe per group |
| ext_rd_n | output | 2 | Active-low read strobe per group |
| ext_wr_n | output | 2 | Active-low write strobe per group |
| ext_ahi | output | 16 | Upper address byte per group |
| ext_alo | output | 16 | Low address byte per group (separate-pin style) |
| ext_dq_o | output | 16 | Data/address output per group |
| ext_dq_oe | output | 2 | Data pin output enable per group |
| ext_dq_i | input | 16 | Data pin input per group |

## Verification
A configuration write can land in the very cycle a request is accepted, and it can also land while an external access is still stepping through its phases. The bench provokes the first case by raising `cfg_wr` together with `req`, switching from external-only to internal-only routing. It provokes the second by rewriting pin style and pin group one cycle into a shared-pin access. Its behavioural model applies the new value only after taking the access's parameters. On every clock it compares the full pin set, `busy` and `done` against that model. It then confirms through `cfg_rdata` and a following access that the write itself did land.

// File: rtl/emc_pkg.sv
package emc_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int HI_W      = ADDR_W - DATA_W;
    localparam int IRAM_AW   = 12;
    localparam int GROUP_CNT = 2;
    localparam int ALEW_W    = 2;
    localparam int CFG_W     = 8;

    localparam logic [CFG_W-1:0]  CFG_RST  = 8'h03;
    localparam logic [CFG_W-1:0]  CFG_MASK = 8'h3F;
    localparam logic [ADDR_W-1:0] SPLIT_AT = ADDR_W'(2 ** IRAM_AW);

    typedef enum logic [1:0] {
        RT_LOCAL       = 2'b00,
        RT_SPLIT_LATCH = 2'b01,
        RT_SPLIT_PAGE  = 2'b10,
        RT_REMOTE      = 2'b11
    } route_e;

    // Field layout of configuration bits 5:0
    typedef struct packed {
        logic               grp_upper;
        logic               sep_bus;
        route_e             route;
        logic [ALEW_W-1:0]  ale_w;
    } cfg_t;

    typedef struct packed {
        logic               ext;
        logic               we;
        logic               grp_upper;
        logic               sep_bus;
        logic [ALEW_W-1:0]  ale_w;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
    } xact_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_ALE_HI,
        SQ_ALE_LO,
        SQ_STROBE
    } seq_e;

    function automatic logic [HI_W-1:0] pick_upper(
        input route_e            rt,
        input logic              is_short,
        input logic [ADDR_W-1:0] a,
        input logic [HI_W-1:0]   latch_v,
        input logic [HI_W-1:0]   page_v
    );
        logic [HI_W-1:0] u;
        if (!is_short)
            u = a[ADDR_W-1:DATA_W];
        else if (rt == RT_SPLIT_LATCH)
            u = latch_v;
        else
            u = page_v;
        return u;
    endfunction

    function automatic logic is_remote(
        input route_e            rt,
        input logic [ADDR_W-1:0] ea
    );
        logic r;
        case (rt)
            RT_LOCAL:  r = 1'b0;
            RT_REMOTE: r = 1'b1;
            default:   r = (ea >= SPLIT_AT);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/emc_route.sv
module emc_route
    import emc_pkg::*;
(
    input  cfg_t              cfg,
    input  logic              req_we,
    input  logic              req_short,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [HI_W-1:0]   latch_v,
    input  logic [HI_W-1:0]   page_v,
    output xact_t             x
);

    logic [HI_W-1:0]   upper;
    logic [ADDR_W-1:0] ea;

    always_comb begin
        upper       = pick_upper(cfg.route, req_short, req_addr, latch_v, page_v);
        ea          = {upper, req_addr[DATA_W-1:0]};
        x.ext       = is_remote(cfg.route, ea);
        x.we        = req_we;
        x.grp_upper = cfg.grp_upper;
        x.sep_bus   = cfg.sep_bus;
        x.ale_w     = cfg.ale_w;
        x.addr      = ea;
        x.wdata     = req_wdata;
    end

endmodule

// File: rtl/emc_iram.sv
module emc_iram
    import emc_pkg::*;
#(
    parameter int AW = IRAM_AW,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we)
                mem[addr] <= wdata;
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/emc_bus_seq.sv
module emc_bus_seq
    import emc_pkg::*;
#(
    parameter int GROUPS = GROUP_CNT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  xact_t                    x,
    input  logic [GROUPS*DATA_W-1:0] dq_i,
    output logic [GROUPS-1:0]        ale,
    output logic [GROUPS-1:0]        rd_n,
    output logic [GROUPS-1:0]        wr_n,
    output logic [GROUPS*HI_W-1:0]   ahi,
    output logic [GROUPS*DATA_W-1:0] alo,
    output logic [GROUPS*DATA_W-1:0] dq_o,
    output logic [GROUPS-1:0]        dq_oe,
    output logic                     busy,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata
);

    seq_e              state;
    logic [ALEW_W-1:0] cnt;
    logic              cur_we;
    logic              cur_grp;
    logic              cur_sep;
    logic [ALEW_W-1:0] cur_alew;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;

    assign busy = (state != SQ_IDLE);

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst) begin
            state     <= SQ_IDLE;
            cnt       <= '0;
            cur_we    <= 1'b0;
            cur_grp   <= 1'b0;
            cur_sep   <= 1'b0;
            cur_alew  <= '0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            rdata     <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start && x.ext) begin
                        cur_we    <= x.we;
                        cur_grp   <= x.grp_upper;
                        cur_sep   <= x.sep_bus;
                        cur_alew  <= x.ale_w;
                        cur_addr  <= x.addr;
                        cur_wdata <= x.wdata;
                        cnt       <= x.ale_w;
                        state     <= x.sep_bus ? SQ_SETUP : SQ_ALE_HI;
                    end
                end
                SQ_SETUP: state <= SQ_STROBE;
                SQ_ALE_HI: begin
                    if (cnt == '0) begin
                        cnt   <= cur_alew;
                        state <= SQ_ALE_LO;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SQ_ALE_LO: begin
                    if (cnt == '0)
                        state <= SQ_STROBE;
                    else
                        cnt <= cnt - 1'b1;
                end
                SQ_STROBE: begin
                    state <= SQ_IDLE;
                    done  <= 1'b1;
                    if (!cur_we)
                        rdata <= dq_i[int'(cur_grp)*DATA_W +: DATA_W];
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_pin
        logic sel;
        logic hi_ph;
        logic stb;

        assign sel   = busy && (int'(cur_grp) == g);
        assign hi_ph = sel && (state == SQ_ALE_HI);
        assign stb   = sel && (state == SQ_STROBE);

        assign ale[g]   = hi_ph;
        assign rd_n[g]  = !(stb && !cur_we);
        assign wr_n[g]  = !(stb && cur_we);
        assign dq_oe[g] = hi_ph || (stb && cur_we);

        assign ahi[g*HI_W +: HI_W]     = sel ? cur_addr[ADDR_W-1:DATA_W] : '0;
        assign alo[g*DATA_W +: DATA_W] = (sel && cur_sep) ? cur_addr[DATA_W-1:0] : '0;
        assign dq_o[g*DATA_W +: DATA_W] = hi_ph            ? cur_addr[DATA_W-1:0] :
                                          (stb && cur_we)  ? cur_wdata : '0;
    end

endmodule

// File: rtl/emc_ctrl.sv
module emc_ctrl
    import emc_pkg::*;
#(
    parameter int GROUPS = GROUP_CNT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_wr,
    input  logic [CFG_W-1:0]         cfg_wdata,
    output logic [CFG_W-1:0]         cfg_rdata,
    input  logic                     page_wr,
    input  logic [HI_W-1:0]          page_wdata,
    output logic [HI_W-1:0]          page_rdata,
    input  logic [HI_W-1:0]          hi_latch,
    input  logic                     req,
    input  logic                     req_we,
    input  logic                     req_short,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     busy,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata,
    output logic [GROUPS-1:0]        ext_ale,
    output logic [GROUPS-1:0]        ext_rd_n,
    output logic [GROUPS-1:0]        ext_wr_n,
    output logic [GROUPS*HI_W-1:0]   ext_ahi,
    output logic [GROUPS*DATA_W-1:0] ext_alo,
    output logic [GROUPS*DATA_W-1:0] ext_dq_o,
    output logic [GROUPS-1:0]        ext_dq_oe,
    input  logic [GROUPS*DATA_W-1:0] ext_dq_i
);

    logic [CFG_W-1:0]  cfg_q;
    logic [HI_W-1:0]   page_q;
    cfg_t              cfg_v;
    xact_t             xa;
    logic              accept;
    logic              int_en;
    logic              int_done;
    logic              ext_done;
    logic [DATA_W-1:0] int_rdata;
    logic [DATA_W-1:0] ext_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_RST;
            page_q <= '0;
        end else begin
            if (cfg_wr)
                cfg_q <= cfg_wdata & CFG_MASK;
            if (page_wr)
                page_q <= page_wdata;
        end
    end

    assign cfg_rdata  = cfg_q;
    assign page_rdata = page_q;
    assign cfg_v      = cfg_t'(cfg_q[$bits(cfg_t)-1:0]);
    assign accept     = req && !busy;
    assign int_en     = accept && !xa.ext;

    emc_route u_route (
        .cfg       (cfg_v),
        .req_we    (req_we),
        .req_short (req_short),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .latch_v   (hi_latch),
        .page_v    (page_q),
        .x         (xa)
    );

    emc_iram #(
        .AW (IRAM_AW),
        .DW (DATA_W)
    ) u_iram (
        .clk   (clk),
        .en    (int_en),
        .we    (xa.we),
        .addr  (xa.addr[IRAM_AW-1:0]),
        .wdata (xa.wdata),
        .rdata (int_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst)
            int_done <= 1'b0;
        else
            int_done <= int_en;
    end

    emc_bus_seq #(
        .GROUPS (GROUPS)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .x     (xa),
        .dq_i  (ext_dq_i),
        .ale   (ext_ale),
        .rd_n  (ext_rd_n),
        .wr_n  (ext_wr_n),
        .ahi   (ext_ahi),
        .alo   (ext_alo),
        .dq_o  (ext_dq_o),
        .dq_oe (ext_dq_oe),
        .busy  (busy),
        .done  (ext_done),
        .rdata (ext_rdata)
    );

    assign done  = int_done || ext_done;
    assign rdata = int_done ? int_rdata : ext_rdata;

endmodule

// File: rtl/emc_ctrl_chk.sv
module emc_ctrl_chk
    import emc_pkg::*;
#(
    parameter int GROUPS = GROUP_CNT
) (
    input logic                     clk,
    input logic                     rst,
    input logic [CFG_W-1:0]         cfg_rdata,
    input logic [HI_W-1:0]          page_rdata,
    input logic                     busy,
    input logic                     done,
    input logic [GROUPS-1:0]        ext_ale,
    input logic [GROUPS-1:0]        ext_rd_n,
    input logic [GROUPS-1:0]        ext_wr_n,
    input logic [GROUPS*HI_W-1:0]   ext_ahi,
    input logic [GROUPS-1:0]        ext_dq_oe
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (cfg_rdata == CFG_RST && page_rdata == '0 && !busy && !done));

    // R2
    cfg_top_bits_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[CFG_W-1:CFG_W-2] == 2'b00);

    // R7
    one_group_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ext_ale | ~ext_rd_n | ~ext_wr_n | ext_dq_oe));

    // R10
    no_rdwr_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        ((~ext_rd_n) & (~ext_wr_n)) == '0);

    // R8
    ale_strobe_apart_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_ale & ~(ext_rd_n & ext_wr_n)) == '0);

    // R10
    done_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (done && $past(busy)) |-> ($past(ext_rd_n) != '1 || $past(ext_wr_n) != '1));

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(ext_ahi));

endmodule

bind emc_ctrl emc_ctrl_chk #(.GROUPS(GROUPS)) u_chk (.*);

// File: tb/emc_ctrl_test.sv
`timescale 1ns/1ps
module emc_ctrl_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [7:0]  cfg_wdata;
    logic [7:0]  cfg_rdata;
    logic        page_wr;
    logic [7:0]  page_wdata;
    logic [7:0]  page_rdata;
    logic [7:0]  hi_latch;
    logic        req;
    logic        req_we;
    logic        req_short;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        busy;
    logic        done;
    logic [7:0]  rdata;
    logic [1:0]  ext_ale;
    logic [1:0]  ext_rd_n;
    logic [1:0]  ext_wr_n;
    logic [15:0] ext_ahi;
    logic [15:0] ext_alo;
    logic [15:0] ext_dq_o;
    logic [1:0]  ext_dq_oe;
    logic [15:0] ext_dq_i;

    always #2.5 clk = ~clk;

    emc_ctrl uut (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .page_wr(page_wr), .page_wdata(page_wdata), .page_rdata(page_rdata),
        .hi_latch(hi_latch),
        .req(req), .req_we(req_we), .req_short(req_short),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata),
        .ext_ale(ext_ale), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
        .ext_ahi(ext_ahi), .ext_alo(ext_alo),
        .ext_dq_o(ext_dq_o), .ext_dq_oe(ext_dq_oe), .ext_dq_i(ext_dq_i)
    );

    int         n_cmp = 0;
    int         n_bad = 0;
    bit         finished = 0;
    logic [7:0] m_cfg;
    logic [7:0] m_page;
    logic [7:0] m_ram [int];

    localparam logic [63:0] IDLE_PINS = {6'b0, 1'b0, 1'b0, 2'b00, 2'b11, 2'b11,
                                         16'h0, 16'h0, 16'h0, 2'b00};

    function automatic logic [63:0] pins_now();
        return {6'b0, busy, done, ext_ale, ext_rd_n, ext_wr_n,
                ext_ahi, ext_alo, ext_dq_o, ext_dq_oe};
    endfunction

    task automatic report(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic wcfg(input logic [7:0] v, input string rq);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        m_cfg = v & 8'h3F;
        report({rq, " cfg readback"}, 64'(cfg_rdata), 64'(m_cfg));
    endtask

    task automatic wpage(input logic [7:0] v, input string rq);
        @(negedge clk);
        page_wr = 1'b1; page_wdata = v;
        @(negedge clk);
        page_wr = 1'b0;
        m_page = v;
        report({rq, " page readback"}, 64'(page_rdata), 64'(m_page));
    endtask

    task automatic access(input bit we, input bit sh, input logic [15:0] a,
                          input logic [7:0] wd, input logic [7:0] dqv,
                          input bit cw_acc, input logic [7:0] cv_acc,
                          input bit cw_mid, input logic [7:0] cv_mid,
                          input string rq);
        logic [1:0]  mode;
        logic [7:0]  upper;
        logic [15:0] ea;
        bit          ext;
        bit          sep;
        int          grp;
        int          w;
        int          total;
        logic [7:0]  exp_rd;
        mode  = m_cfg[3:2];
        upper = !sh ? a[15:8] : (mode == 2'b01 ? hi_latch : m_page);
        ea    = {upper, a[7:0]};
        ext   = (mode == 2'b11) ? 1'b1 : (mode == 2'b00) ? 1'b0 : (ea >= 16'h1000);
        sep   = m_cfg[4];
        grp   = int'(m_cfg[5]);
        w     = int'(m_cfg[1:0]) + 1;
        total = !ext ? 1 : (sep ? 3 : 2 * w + 2);
        if (ext)
            exp_rd = dqv;
        else
            exp_rd = m_ram.exists(int'(ea[11:0])) ? m_ram[int'(ea[11:0])] : 8'h00;
        if (!ext && we)
            m_ram[int'(ea[11:0])] = wd;

        @(negedge clk);
        req = 1'b1; req_we = we; req_short = sh; req_addr = a; req_wdata = wd;
        ext_dq_i = {dqv, dqv};
        cfg_wr = cw_acc; cfg_wdata = cv_acc;
        @(posedge clk);
        if (cw_acc) m_cfg = cv_acc & 8'h3F;

        for (int i = 1; i <= total; i++) begin
            logic [1:0]  e_ale;
            logic [1:0]  e_rdn;
            logic [1:0]  e_wrn;
            logic [1:0]  e_oe;
            logic [15:0] e_ahi;
            logic [15:0] e_alo;
            logic [15:0] e_dqo;
            bit          alehi;
            bit          stb;
            bit          e_busy;
            bit          e_done;
            @(negedge clk);
            if (i == 1) begin
                req = 1'b0;
                cfg_wr = cw_mid; cfg_wdata = cv_mid;
            end
            if (i == 2) cfg_wr = 1'b0;
            e_ale = '0; e_rdn = '1; e_wrn = '1; e_oe = '0;
            e_ahi = '0; e_alo = '0; e_dqo = '0;
            e_busy = ext && (i < total);
            e_done = (i == total);
            if (e_busy) begin
                alehi = !sep && (i <= w);
                stb   = (i == total - 1);
                e_ahi[grp*8 +: 8] = upper;
                if (sep) e_alo[grp*8 +: 8] = a[7:0];
                e_ale[grp] = alehi;
                if (alehi) begin
                    e_dqo[grp*8 +: 8] = a[7:0];
                    e_oe[grp] = 1'b1;
                end
                if (stb && we) begin
                    e_dqo[grp*8 +: 8] = wd;
                    e_oe[grp] = 1'b1;
                    e_wrn[grp] = 1'b0;
                end
                if (stb && !we) e_rdn[grp] = 1'b0;
            end
            report($sformatf("%s pins cycle %0d", rq, i), pins_now(),
                   {6'b0, e_busy, e_done, e_ale, e_rdn, e_wrn, e_ahi, e_alo, e_dqo, e_oe});
            if (e_done && !we)
                report({rq, " rdata"}, 64'(rdata), 64'(exp_rd));
        end
        cfg_wr = 1'b0;
        if (cw_mid) m_cfg = cv_mid & 8'h3F;
    endtask

    task automatic acc(input bit we, input bit sh, input logic [15:0] a,
                       input logic [7:0] wd, input logic [7:0] dqv, input string rq);
        access(we, sh, a, wd, dqv, 1'b0, 8'h00, 1'b0, 8'h00, rq);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        rst = 1'b1; cfg_wr = 1'b0; cfg_wdata = '0; page_wr = 1'b0; page_wdata = '0;
        hi_latch = '0; req = 1'b0; req_we = 1'b0; req_short = 1'b0;
        req_addr = '0; req_wdata = '0; ext_dq_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_cfg = 8'h03; m_page = 8'h00;
        report("R1 cfg reset", 64'(cfg_rdata), 64'h03);
        report("R1 page reset", 64'(page_rdata), 64'h00);
        report("R1 idle pins", pins_now(), IDLE_PINS);

        // R2: top bits dropped, low bits kept
        wcfg(8'hFF, "R2");
        wcfg(8'h00, "R2");

        // R3: internal only with aliasing
        acc(1'b1, 1'b0, 16'h5123, 8'hA5, 8'h00, "R3 write alias");
        acc(1'b0, 1'b0, 16'h0123, 8'h00, 8'h00, "R3 read");
        acc(1'b0, 1'b0, 16'hF123, 8'h00, 8'h00, "R3 read alias");

        wpage(8'h44, "R5");

        // R4: split by latch, shared pins, width 2
        wcfg(8'h05, "R4");
        acc(1'b1, 1'b0, 16'h0FFF, 8'h3C, 8'h00, "R4 below boundary write");
        acc(1'b0, 1'b0, 16'h0FFF, 8'h00, 8'h00, "R4 below boundary read");
        acc(1'b0, 1'b0, 16'h1000, 8'h00, 8'h77, "R4 R8 R10 boundary read");
        acc(1'b1, 1'b0, 16'h2345, 8'h99, 8'h00, "R8 R10 write");
        hi_latch = 8'h00;
        acc(1'b1, 1'b1, 16'hFF12, 8'h11, 8'h00, "R4 short internal write");
        acc(1'b0, 1'b1, 16'h0012, 8'h00, 8'h00, "R4 short internal read");
        hi_latch = 8'h20;
        acc(1'b0, 1'b1, 16'h0034, 8'h00, 8'hC3, "R4 short latch read");

        // R5 R7 R9: split by page, separate pins, group 1
        wcfg(8'h38, "R5");
        acc(1'b0, 1'b1, 16'h0056, 8'h00, 8'h5A, "R5 R7 R9 short read");
        acc(1'b1, 1'b1, 16'h0057, 8'h6B, 8'h00, "R5 R7 R9 short write");
        wpage(8'h05, "R5");
        acc(1'b1, 1'b1, 16'h0060, 8'h2E, 8'h00, "R5 short page internal");
        acc(1'b0, 1'b0, 16'h0560, 8'h00, 8'h00, "R5 internal readback");

        // R6: external only, width 4
        wcfg(8'h0F, "R6");
        acc(1'b0, 1'b0, 16'h0010, 8'h00, 8'h81, "R6 R8 low address external");
        wpage(8'h44, "R6");
        acc(1'b1, 1'b1, 16'h00AB, 8'h4D, 8'h00, "R6 short page write");

        // R7 R8: group 1, shared pins, width 3
        wcfg(8'h2E, "R7");
        acc(1'b0, 1'b0, 16'h8000, 8'h00, 8'hE7, "R7 R8 group1 read");

        // R11: write in the acceptance cycle
        wcfg(8'h0D, "R11");
        access(1'b0, 1'b0, 16'h0010, 8'h00, 8'h3D, 1'b1, 8'h00, 1'b0, 8'h00,
               "R11 write at accept");
        report("R11 cfg after accept write", 64'(cfg_rdata), 64'h00);
        acc(1'b0, 1'b0, 16'h0123, 8'h00, 8'h00, "R11 new cfg internal");

        // R11: write during the access
        wcfg(8'h0D, "R11");
        access(1'b1, 1'b0, 16'h3000, 8'h5E, 8'h00, 1'b0, 8'h00, 1'b1, 8'h33,
               "R11 write mid access");
        report("R11 cfg after mid write", 64'(cfg_rdata), 64'h33);
        @(negedge clk);
        report("R1 idle at end", pins_now(), IDLE_PINS);

        finish_run();
    end

endmodule